// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo PCM bit stream into parallel samples. It takes three serial inputs: a bit clock, a frame clock and a data line. It works out where each channel's word sits in the frame, and it presents a left and a right sample of 24 bits each. A one-cycle strobe marks every complete stereo pair. All three serial inputs are oversampled by the block's own system clock. The bit clock must therefore stay at or below a quarter of the system clock rate.

Five framing conventions are supported. They differ in frame-clock polarity, in how far the MSB sits from the slot boundary, and in which bit-clock edge samples the data. One of them marks slots with a short pulse on the frame clock instead of a level. Word length comes from two 2-bit selects, one intended for board straps and one for a register field. The two selects are combined, so either source can be used while the other is held at zero. The format select and the width selects are static and are changed only while reset is asserted.

Top module: `pcm_rx`

## Requirements
- R1: While reset is high, and after it falls until the first stereo pair completes, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: Format code 0 (level-framed, MSB-first alignment): the frame clock is high for the left slot. The first rising bit-clock edge after a frame-clock change carries the MSB.
- R3: Format code 1 (I2S): the frame clock is low for the left slot. The MSB arrives on the second rising bit-clock edge after the frame-clock change.
- R4: Format code 2 (LSB-end alignment, 32 bit clocks per slot): the frame clock is high for left. The MSB is taken 16 rising edges after the frame-clock change, so the LSB is the last bit of the slot. The word is always 16 bits and both width selects are disregarded.
- R5: Format code 3 (pulse-framed): data is sampled on falling bit-clock edges. A frame-clock pulse high precedes each slot, and the MSB is the bit after the pulse. The first pulse after reset opens a left slot, and later pulses alternate right, left, and so on.
- R6: Format code 4 (packed, 16 bit clocks per slot): the frame clock is high for left. The MSB comes at the frame-clock change and the word is always 16 bits. Both width selects are disregarded.
- R7: For formats 0, 1 and 3 the word length code is the bitwise OR of `width_pin_i` and `width_reg_i`. Code 00 selects 16 bits, 01 selects 18, 10 selects 20 and 11 selects 24.
- R8: Slot bits before the MSB position or beyond the selected word length have no effect on the sample outputs.
- R9: Each sample is output in two's complement, sign-extended from its word length to 24 bits.
- R10: `valid_o` goes high for exactly one cycle once a right-channel word completes after a completed left word. Both outputs change in that cycle only and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame clock (level or pulse, per format) |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 3 | Framing format code 0..4 |
| width_pin_i | input | 2 | Word length select from straps |
| width_reg_i | input | 2 | Word length select from a register field |
| left_o | output | 24 | Left sample, sign-extended |
| right_o | output | 24 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The assertions check properties that hold on every cycle. The strobe lasts one cycle. Both outputs hold between strobes. A pair is never emitted without a left word captured before it. No slot captures more bits than the word length allows. In the two fixed 16-bit formats, every emitted sample has a clean sign extension above bit 15. Only the bench scenarios can show the rest. Those scenarios cover bit alignment for each format, channel steering under each frame-clock polarity, the alternation of pulse-framed slots, the OR of the width selects and the rejection of filler bits. The bench checks these against full-scale, minimum, all-ones, zero and hashed words at every word length.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

    localparam int SAMPLE_W = 24;

    typedef enum logic [2:0] {
        FMT_LJ   = 3'd0,
        FMT_I2S  = 3'd1,
        FMT_RJ   = 3'd2,
        FMT_DSP  = 3'd3,
        FMT_PACK = 3'd4
    } fmt_e;

    typedef logic [SAMPLE_W-1:0] sample_t;

    // One received slot bit handed from the framer to the assembler
    typedef struct packed {
        logic stb;
        logic dat;
        logic first;
        logic last;
        logic left;
    } slot_bit_t;

    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 18;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

    // Fixed-length formats ignore both selects
    function automatic logic [1:0] merge_width(input fmt_e fmt,
                                               input logic [1:0] pin_w,
                                               input logic [1:0] reg_w);
        if (fmt == FMT_RJ || fmt == FMT_PACK)
            return 2'b00;
        return pin_w | reg_w;
    endfunction

    function automatic sample_t sign_ext(input sample_t v, input logic [1:0] code);
        sample_t r;
        int      w;
        w = word_bits(code);
        for (int i = 0; i < SAMPLE_W; i++)
            r[i] = (i < w) ? v[i] : v[w-1];
        return r;
    endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sdata_i,
    output logic rise_o,
    output logic fall_o,
    output logic lr_o,
    output logic dat_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] bclk_q, lr_q, dat_q;
    logic         bclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q    <= '0;
            lr_q      <= '0;
            dat_q     <= '0;
            bclk_prev <= 1'b0;
        end else begin
            bclk_q    <= {bclk_q[TOP-1:0], bclk_i};
            lr_q      <= {lr_q[TOP-1:0], lrclk_i};
            dat_q     <= {dat_q[TOP-1:0], sdata_i};
            bclk_prev <= bclk_q[TOP];
        end
    end

    assign rise_o = bclk_q[TOP] & ~bclk_prev;
    assign fall_o = ~bclk_q[TOP] & bclk_prev;
    assign lr_o   = lr_q[TOP];
    assign dat_o  = dat_q[TOP];

endmodule

// File: rtl/pcm_rx_frame.sv
module pcm_rx_frame
    import pcm_rx_pkg::*;
#(
    parameter int SLOT_BITS = 32
) (
    input  logic      clk,
    input  logic      rst,
    input  fmt_e      fmt,
    input  logic [1:0] wcode,
    input  logic      rise,
    input  logic      fall,
    input  logic      lr,
    input  logic      dat,
    output slot_bit_t bit_o
);
    localparam int             CNT_W   = $clog2(SLOT_BITS) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int             RJ_DLY  = SLOT_BITS - 16;

    logic             primed, lr_prev, in_slot, slot_left, dsp_left_next;
    logic [CNT_W-1:0] cnt, pos;
    logic             act, start, start_left, cur_left, live, in_rng;
    int               dly, idx, wbits;

    always_comb begin
        act   = (fmt == FMT_DSP) ? fall : rise;
        start = primed & ((fmt == FMT_DSP) ? (lr & ~lr_prev) : (lr ^ lr_prev));
        pos   = start ? '0 : cnt;
        case (fmt)
            FMT_I2S, FMT_DSP: dly = 1;
            FMT_RJ:           dly = RJ_DLY;
            default:          dly = 0;
        endcase
        wbits = word_bits(wcode);
        idx   = int'(pos) - dly;
        live  = start | in_slot;
        in_rng = live && (idx >= 0) && (idx < wbits);
        case (fmt)
            FMT_DSP: start_left = dsp_left_next;
            FMT_I2S: start_left = ~lr;
            default: start_left = lr;
        endcase
        cur_left = start ? start_left : slot_left;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed        <= 1'b0;
            lr_prev       <= 1'b0;
            cnt           <= '0;
            in_slot       <= 1'b0;
            slot_left     <= 1'b0;
            dsp_left_next <= 1'b1;
            bit_o         <= '0;
        end else begin
            bit_o.stb <= 1'b0;
            if (act) begin
                primed  <= 1'b1;
                lr_prev <= lr;
                cnt     <= (pos == CNT_MAX) ? pos : pos + 1'b1;
                if (start) begin
                    in_slot   <= 1'b1;
                    slot_left <= start_left;
                    if (fmt == FMT_DSP)
                        dsp_left_next <= ~dsp_left_next;
                end
                bit_o.stb   <= in_rng;
                bit_o.dat   <= dat;
                bit_o.first <= (idx == 0);
                bit_o.last  <= (idx == wbits - 1);
                bit_o.left  <= cur_left;
            end
        end
    end

endmodule

// File: rtl/pcm_rx_pack.sv
module pcm_rx_pack
    import pcm_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_bit_t  bit_i,
    input  logic [1:0] wcode,
    output sample_t    left_o,
    output sample_t    right_o,
    output logic       valid_o
);
    sample_t    shreg, nxt, hold;
    logic       left_rdy;
    logic [4:0] nbits;

    assign nxt = bit_i.first ? {{(SAMPLE_W-1){1'b0}}, bit_i.dat}
                             : {shreg[SAMPLE_W-2:0], bit_i.dat};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            hold     <= '0;
            left_rdy <= 1'b0;
            left_o   <= '0;
            right_o  <= '0;
            valid_o  <= 1'b0;
            nbits    <= '0;
        end else begin
            valid_o <= 1'b0;
            if (bit_i.stb) begin
                shreg <= nxt;
                nbits <= bit_i.first ? 5'd1 : nbits + 5'd1;
                if (bit_i.last) begin
                    if (bit_i.left) begin
                        hold     <= sign_ext(nxt, wcode);
                        left_rdy <= 1'b1;
                    end else if (left_rdy) begin
                        left_o   <= hold;
                        right_o  <= sign_ext(nxt, wcode);
                        valid_o  <= 1'b1;
                        left_rdy <= 1'b0;
                    end
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R10
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R10
    AST_LEFT_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(left_rdy)); // R10
    AST_BIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (bit_i.stb && !bit_i.first) |-> (int'(nbits) < word_bits(wcode))); // R8

endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
    import pcm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SLOT_BITS   = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bclk_i,
    input  logic        lrclk_i,
    input  logic        sdata_i,
    input  logic [2:0]  fmt_i,
    input  logic [1:0]  width_pin_i,
    input  logic [1:0]  width_reg_i,
    output logic [23:0] left_o,
    output logic [23:0] right_o,
    output logic        valid_o
);
    fmt_e       fmt;
    logic [1:0] wcode;
    logic       rise, fall, lr_s, dat_s;
    slot_bit_t  sbit;

    assign fmt   = fmt_e'(fmt_i);
    assign wcode = merge_width(fmt, width_pin_i, width_reg_i);

    pcm_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .bclk_i(bclk_i), .lrclk_i(lrclk_i), .sdata_i(sdata_i),
        .rise_o(rise), .fall_o(fall), .lr_o(lr_s), .dat_o(dat_s)
    );

    pcm_rx_frame #(.SLOT_BITS(SLOT_BITS)) i_frame (
        .clk(clk), .rst(rst), .fmt(fmt), .wcode(wcode),
        .rise(rise), .fall(fall), .lr(lr_s), .dat(dat_s), .bit_o(sbit)
    );

    pcm_rx_pack i_pack (
        .clk(clk), .rst(rst), .bit_i(sbit), .wcode(wcode),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    AST_SEXT16: assert property (@(posedge clk) disable iff (rst)
        (valid_o && (fmt == FMT_RJ || fmt == FMT_PACK)) |->
        (($countones(left_o[23:15]) == 0 || $countones(left_o[23:15]) == 9) &&
         ($countones(right_o[23:15]) == 0 || $countones(right_o[23:15]) == 9))); // R9

endmodule

// File: tb/test_pcm_rx.sv
module test_pcm_rx;

    localparam int HALF    = 4;
    localparam int NFRAMES = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic [1:0]  wpin = 2'b00, wreg = 2'b00;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int errors = 0;
    int checks = 0;
    int cap_n  = 0;
    logic [23:0] cap_l [0:511];
    logic [23:0] cap_r [0:511];

    always #10 clk = ~clk;

    pcm_rx i_pcm_rx (
        .clk(clk), .rst(rst), .bclk_i(bclk), .lrclk_i(lrclk), .sdata_i(sdata),
        .fmt_i(fmt), .width_pin_i(wpin), .width_reg_i(wreg),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );

    always @(negedge clk) begin
        if (!rst && valid_o && cap_n < 512) begin
            cap_l[cap_n] = left_o;
            cap_r[cap_n] = right_o;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int wlen(input int f, input logic [1:0] code);
        if (f == 2 || f == 4) return 16;
        case (code)
            2'b00: return 16;
            2'b01: return 18;
            2'b10: return 20;
            default: return 24;
        endcase
    endfunction

    // Raw word, only the low wb bits are meaningful
    function automatic logic [23:0] gen(input int k, input int wb);
        logic [31:0] h;
        case (k)
            0: return 24'((32'd1 << (wb - 1)) - 1);
            1: return 24'(32'd1 << (wb - 1));
            2: return 24'hFFFFFF;
            3: return 24'h000000;
            default: begin
                h = 32'(k) * 32'h9E3779B1;
                return h[27:4];
            end
        endcase
    endfunction

    function automatic logic [23:0] expect_val(input logic [23:0] raw, input int wb);
        longint v;
        v = longint'(raw & 24'((32'd1 << wb) - 1));
        if (raw[wb-1]) v = v - (longint'(1) << wb);
        return 24'(v);
    endfunction

    task automatic send_bit(input logic lr, input logic d, input bit dsp);
        @(negedge clk);
        bclk = dsp; lrclk = lr; sdata = d;
        repeat (HALF) @(negedge clk);
        bclk = ~dsp;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_frame(input int f, input int wb, input logic [23:0] l, input logic [23:0] r);
        int slot, d, i;
        logic lr, b;
        logic [23:0] w;
        slot = (f == 4) ? 16 : 32;
        d = (f == 1 || f == 3) ? 1 : (f == 2) ? 16 : 0;
        for (int ch = 0; ch < 2; ch++) begin
            w = (ch == 0) ? l : r;
            for (int p = 0; p < slot; p++) begin
                if (f == 3)      lr = (p == 0);
                else if (f == 1) lr = (ch == 1);
                else             lr = (ch == 0);
                i = p - d;
                b = (i >= 0 && i < wb) ? w[wb-1-i] : 1'b1; // filler is ignored (R8)
                send_bit(lr, b, f == 3);
            end
        end
    endtask

    task automatic run_cfg(input int f, input logic [1:0] pin, input logic [1:0] rg, input string tag);
        int wb, base;
        logic idle_lr;
        @(negedge clk);
        rst = 1'b1;
        fmt = 3'(f); wpin = pin; wreg = rg;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check({"R1 left ", tag}, 32'(left_o), 32'd0);
        check({"R1 valid ", tag}, 32'(valid_o), 32'd0);
        wb = wlen(f, pin | rg);
        idle_lr = (f == 1);
        base = cap_n;
        for (int k = 0; k < 4; k++) send_bit(idle_lr, 1'b0, f == 3);
        for (int n = 0; n < NFRAMES; n++)
            send_frame(f, wb, gen(2 * n, wb), gen(2 * n + 1, wb));
        for (int k = 0; k < 4; k++) send_bit(idle_lr, 1'b0, f == 3);
        repeat (10) @(negedge clk);
        check({"R10 pair count ", tag}, 32'(cap_n - base), 32'(NFRAMES));
        for (int n = 0; n < NFRAMES && base + n < cap_n; n++) begin
            check({"R8 R9 left ", tag}, 32'(cap_l[base+n]), 32'(expect_val(gen(2 * n, wb), wb)));
            check({"R8 R9 right ", tag}, 32'(cap_r[base+n]), 32'(expect_val(gen(2 * n + 1, wb), wb)));
        end
    endtask

    task automatic run_all;
        for (int c = 0; c < 4; c++)
            run_cfg(0, 2'(c) & 2'b10, 2'(c) & 2'b01, "R2 R7 lj");
        for (int c = 0; c < 4; c++)
            run_cfg(1, 2'(c), 2'b00, "R3 R7 i2s");
        for (int c = 0; c < 4; c++)
            run_cfg(3, 2'b00, 2'(c), "R5 R7 pulse");
        run_cfg(2, 2'b11, 2'b11, "R4 rj");
        run_cfg(4, 2'b01, 2'b10, "R6 packed");
    endtask

    initial begin
        fork
            run_all;
            begin
                repeat (190000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule